// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit half of a packet DMA engine. Software builds a ring of 8-byte descriptors in memory, points the block at the ring base and then pulses the activation input. The walker then reads descriptors one by one through a simple memory master port. For each owned descriptor it fetches the referenced buffer bytes. Buffers chained up to one marked as last form one frame, which is streamed out as bytes with start and end markers. After each descriptor is used, its ownership bit is cleared and its header word is written back.

Each descriptor that is used produces a per-buffer event pulse. A completed frame also produces a per-frame event pulse. A frame that would grow past the size cap is cut short, and this produces an overrun event pulse. The descriptor pointer is kept from one activation to the next. A wrap flag sends the walk back to the ring base. One activation uses at most a fixed number of descriptors.

Top module: `txw_walker`

## Requirements
- R1: A descriptor at pointer P is the word at P, which holds flags in bits 31:16 and byte length in bits 15:0, followed by the word at P+4, which holds the buffer byte address. Memory words are big-endian: the byte at an address whose low bits are 0 sits in bits 31:24. Buffers may start at any byte address.
- R2: The walk ends at the first descriptor whose flags bit 15 (owned) is clear. That descriptor is not written, and the pointer stays on it.
- R3: One activation consumes at most MAX_DESC descriptors. The next activation resumes at the following descriptor.
- R4: Every consumed descriptor has its header word written back with bit 15 cleared and all other flag bits and the length unchanged. One `ev_txb` pulse is raised for it.
- R5: Frame bytes leave in buffer order. `tx_sop` marks the first byte of a frame, and `tx_eop` marks the final byte once a descriptor with flags bit 11 (last) has been used, even if that descriptor adds no bytes. Each such descriptor raises `ev_txf`. A frame with no bytes emits nothing but still raises `ev_txf`.
- R6: A frame carries at most MAX_FRAME bytes. A descriptor whose length exceeds the remaining room contributes only what fits and raises `ev_babt`.
- R7: After a descriptor with flags bit 13 (wrap), the pointer returns to the ring base. Otherwise it advances by 8.
- R8: A ring base write clears bits 1:0 of the value. When the engine is idle, the write also moves the pointer to that base.
- R9: Activation is ignored when `ctrl_en` is low, and also while a walk is in progress.
- R10: While `tx_valid` is high and `tx_ready` is low, the byte and its markers hold steady.
- R11: A memory request holds its address, direction and write data until `mem_ack`.
- R12: After reset there is no memory request, no stream byte and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_en | input | 1 | Controller enable; gates activation |
| kick | input | 1 | Activation pulse |
| base_wr | input | 1 | Ring base write strobe |
| base_in | input | 32 | Ring base value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory word byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Final byte of frame |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream consumer ready |
| ev_txb | output | 1 | Descriptor consumed pulse |
| ev_txf | output | 1 | Frame completed pulse |
| ev_babt | output | 1 | Frame truncated pulse |

## Verification
The bench builds the walker with MAX_DESC set to 5 and MAX_FRAME set to 20. With a descriptor limit of 5, a single activation runs out before reaching an unowned slot, so the resume behaviour can be seen within a short run. With a 20-byte cap, two 12-byte buffers are enough to force truncation, and the next buffer in the same frame then contributes nothing. Memory latency and stream back-pressure are varied between scenarios, so request holding and byte holding are both exercised.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
  localparam logic [31:0] DESC_STRIDE = 32'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_PTR, S_DATA, S_PUSH, S_FLUSH, S_WB
  } walk_st_e;

  // bytes of a buffer that still fit in the frame
  function automatic logic [15:0] take_len(input logic [15:0] sofar,
                                           input logic [15:0] len,
                                           input logic [15:0] cap);
    logic [15:0] room;
    room = cap - sofar;
    return (len > room) ? room : len;
  endfunction

  function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic wrap);
    return wrap ? base : cur + DESC_STRIDE;
  endfunction

  // big-endian lane pick: lane 0 is the most significant byte
  function automatic logic [7:0] lane_byte(input logic [31:0] word,
                                           input logic [1:0] lane);
    return word[8*(3-int'(lane)) +: 8];
  endfunction
endpackage

// File: rtl/txw_frame_acc.sv
module txw_frame_acc #(
  parameter int MAX_FRAME = 2032
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] desc_len,
  input  logic        close,
  output logic [15:0] take,
  output logic        trunc,
  output logic [15:0] frame_len
);
  import txw_pkg::*;
  localparam logic [15:0] CAP = 16'(MAX_FRAME);

  logic [15:0] take_now;
  assign take_now = take_len(frame_len, desc_len, CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= '0;
      trunc     <= 1'b0;
      frame_len <= '0;
    end else begin
      if (start) begin
        take      <= take_now;
        trunc     <= (take_now != desc_len);
        frame_len <= frame_len + take_now;
      end
      if (close) frame_len <= '0;
    end
  end

  assert_frame_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= CAP);
  assert_take_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> take <= $past(desc_len));
endmodule

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
  parameter int MAX_DESC = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_wr,
  input  logic [31:0] base_in,
  input  logic        idle,
  input  logic        kick_go,
  input  logic        step,
  input  logic        wrap,
  output logic [31:0] cur,
  output logic        last_slot
);
  import txw_pkg::*;
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  logic [31:0]      base;
  logic [CNT_W-1:0] cnt;

  assign last_slot = (cnt == CNT_W'(MAX_DESC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
      cnt  <= '0;
    end else begin
      if (base_wr) base <= {base_in[31:2], 2'b00};
      if (base_wr && idle)  cur <= {base_in[31:2], 2'b00};
      else if (step)        cur <= next_desc(cur, base, wrap);
      if (kick_go)   cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
    end
  end

  assert_desc_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt < CNT_W'(MAX_DESC));
  assert_base_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && idle) |=> (cur == base) && (cur[1:0] == 2'b00));
endmodule

// File: rtl/txw_out_hold.sv
module txw_out_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_push,
  input  logic       in_flush,
  input  logic [7:0] new_byte,
  input  logic       tx_ready,
  output logic       push_go,
  output logic       flush_go,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_sop,
  output logic       tx_eop
);
  logic hold_v, in_frame;

  assign push_go  = in_push  && (!hold_v || tx_ready);
  assign flush_go = in_flush && (!hold_v || tx_ready);
  assign tx_valid = hold_v && (in_push || in_flush);
  assign tx_eop   = in_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      in_frame <= 1'b0;
      tx_data  <= '0;
      tx_sop   <= 1'b0;
    end else if (push_go) begin
      hold_v   <= 1'b1;
      tx_data  <= new_byte;
      tx_sop   <= !in_frame;
      in_frame <= 1'b1;
    end else if (flush_go) begin
      hold_v   <= 1'b0;
      in_frame <= 1'b0;
    end
  end

  assert_stream_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_sop)
                                && $stable(tx_eop));
endmodule

// File: rtl/txw_walker.sv
module txw_walker #(
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_en,
  input  logic        kick,
  input  logic        base_wr,
  input  logic [31:0] base_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        ev_txb,
  output logic        ev_txf,
  output logic        ev_babt
);
  import txw_pkg::*;

  walk_st_e    st;
  logic [15:0] flags_q, len_q, remain;
  logic [31:0] baddr, word_q, ring_cur;
  logic [15:0] take, frame_len;
  logic        trunc, last_slot, push_go, flush_go;

  // named internal events
  logic busy, mem_done, kick_go, hdr_ok, wb_done, is_last;
  logic [7:0] new_byte;
  walk_st_e after_buf;

  assign busy      = (st != S_IDLE);
  assign mem_done  = mem_req && mem_ack;
  assign kick_go   = (st == S_IDLE) && kick && ctrl_en;
  assign hdr_ok    = (st == S_HDR) && mem_done && mem_rdata[16 + FLG_READY];
  assign wb_done   = (st == S_WB) && mem_done;
  assign is_last   = flags_q[FLG_LAST];
  assign new_byte  = lane_byte(word_q, baddr[1:0]);
  assign after_buf = is_last ? S_FLUSH : S_WB;

  txw_ring_ptr #(.MAX_DESC(MAX_DESC)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_in(base_in),
    .idle(!busy), .kick_go(kick_go), .step(wb_done),
    .wrap(flags_q[FLG_WRAP]), .cur(ring_cur), .last_slot(last_slot));

  txw_frame_acc #(.MAX_FRAME(MAX_FRAME)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(hdr_ok), .desc_len(mem_rdata[15:0]),
    .close(flush_go), .take(take), .trunc(trunc), .frame_len(frame_len));

  txw_out_hold u_out (
    .clk(clk), .rst_n(rst_n), .in_push(st == S_PUSH), .in_flush(st == S_FLUSH),
    .new_byte(new_byte), .tx_ready(tx_ready), .push_go(push_go),
    .flush_go(flush_go), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ring_cur;
    mem_wdata = {flags_q & ~(16'd1 << FLG_READY), len_q};
    case (st)
      S_HDR:  mem_req = 1'b1;
      S_PTR:  begin mem_req = 1'b1; mem_addr = ring_cur + 32'd4; end
      S_DATA: begin mem_req = 1'b1; mem_addr = {baddr[31:2], 2'b00}; end
      S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      flags_q <= '0;
      len_q   <= '0;
      remain  <= '0;
      baddr   <= '0;
      word_q  <= '0;
      ev_txb  <= 1'b0;
      ev_txf  <= 1'b0;
      ev_babt <= 1'b0;
    end else begin
      ev_txb  <= wb_done;
      ev_txf  <= wb_done && is_last;
      ev_babt <= wb_done && trunc;
      case (st)
        S_IDLE: if (kick_go) st <= S_HDR;
        S_HDR: if (mem_done) begin
          if (hdr_ok) begin
            flags_q <= mem_rdata[31:16];
            len_q   <= mem_rdata[15:0];
            st      <= S_PTR;
          end else st <= S_IDLE;
        end
        S_PTR: if (mem_done) begin
          baddr  <= mem_rdata;
          remain <= take;
          st     <= (take == 16'd0) ? after_buf : S_DATA;
        end
        S_DATA: if (mem_done) begin
          word_q <= mem_rdata;
          st     <= S_PUSH;
        end
        S_PUSH: if (push_go) begin
          baddr  <= baddr + 32'd1;
          remain <= remain - 16'd1;
          if (remain == 16'd1)          st <= after_buf;
          else if (baddr[1:0] == 2'd3)  st <= S_DATA;
        end
        S_FLUSH: if (flush_go) st <= S_WB;
        S_WB: if (mem_done) st <= last_slot ? S_IDLE : S_HDR;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_en) && $past(kick));
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));
  assert_frame_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txf |-> ev_txb);
  assert_babt_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babt |-> ev_txb);
  assert_wb_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[16 + FLG_READY]);
endmodule

// File: tb/txw_walker_test.sv
`timescale 1ns/1ps
module txw_walker_test;
  localparam int MD = 5;
  localparam int MF = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_en = 1'b0, kick = 1'b0, base_wr = 1'b0;
  logic [31:0] base_in = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0] tx_data;
  logic tx_sop, tx_eop, tx_valid, tx_ready = 1'b1;
  logic ev_txb, ev_txf, ev_babt;

  always #2 clk = ~clk;

  txw_walker #(.MAX_DESC(MD), .MAX_FRAME(MF)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .kick(kick),
    .base_wr(base_wr), .base_in(base_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .ev_txb(ev_txb),
    .ev_txf(ev_txf), .ev_babt(ev_babt));

  logic [31:0] bm [0:255];
  int n_chk = 0, n_bad = 0, done = 0;
  int bp = 0, mem_lat = 0, lat_cnt = 0, tick = 0;
  int n_txb = 0, n_txf = 0, n_babt = 0, saw_req = 0;
  logic [7:0] cap_d [0:127]; logic cap_s [0:127]; logic cap_e [0:127]; int cap_n = 0;
  logic [7:0] exp_d [0:127]; logic exp_s [0:127]; logic exp_e [0:127]; int exp_n = 0;
  int exp_first = 0;
  logic prev_stall = 1'b0, prev_wait = 1'b0;
  logic [7:0] prev_data = '0;
  logic [31:0] prev_addr = '0;

  function automatic logic [7:0] fb(input logic [31:0] a);
    return 8'((a * 32'd7) + 32'd3);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    if (prev_stall) chk("R10", "held byte", {23'd0, tx_valid, tx_data}, {24'd1, prev_data});
    tx_ready = (bp != 0) ? (tick % 3 == 0) : 1'b1;
    if (tx_valid && tx_ready && cap_n < 128) begin
      cap_d[cap_n] = tx_data; cap_s[cap_n] = tx_sop; cap_e[cap_n] = tx_eop; cap_n++;
    end
    prev_stall = tx_valid && !tx_ready;
    prev_data  = tx_data;
    if (ev_txb) n_txb++;
    if (ev_txf) n_txf++;
    if (ev_babt) n_babt++;
    if (mem_req) saw_req = 1;
    if (prev_wait) chk("R11", "request address held", mem_addr, prev_addr);
    prev_wait = 1'b0;
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        lat_cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) bm[mem_addr[9:2]] = mem_wdata;
        else mem_rdata = bm[mem_addr[9:2]];
      end else begin
        lat_cnt++;
        prev_wait = 1'b1;
        prev_addr = mem_addr;
      end
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [15:0] fl,
                          input logic [15:0] ln, input logic [31:0] buf_a);
    bm[a[9:2]] = {fl, ln};
    bm[a[9:2] + 8'd1] = buf_a;
  endtask

  task automatic clear_obs();
    cap_n = 0; exp_n = 0; exp_first = 0;
    n_txb = 0; n_txf = 0; n_babt = 0; saw_req = 0;
  endtask

  task automatic exp_bytes(input logic [31:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      exp_d[exp_n] = fb(a + 32'(k));
      exp_s[exp_n] = (exp_n == exp_first);
      exp_e[exp_n] = 1'b0;
      exp_n++;
    end
  endtask

  task automatic exp_close();
    if (exp_n > exp_first) exp_e[exp_n-1] = 1'b1;
    exp_first = exp_n;
  endtask

  task automatic cmp_stream(input string req);
    chk(req, "byte count", 32'(cap_n), 32'(exp_n));
    for (int k = 0; k < exp_n && k < cap_n; k++)
      chk(req, $sformatf("byte %0d data/sop/eop", k),
          {22'd0, cap_s[k], cap_e[k], cap_d[k]}, {22'd0, exp_s[k], exp_e[k], exp_d[k]});
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk) begin base_wr = 1'b1; base_in = v; end
    @(negedge clk) base_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      quiet = (!mem_req && !tx_valid) ? quiet + 1 : 0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "idle outputs after reset",
        {27'd0, mem_req, tx_valid, ev_txb, ev_txf, ev_babt}, 32'd0);
  endtask

  task automatic t_enable_gate();
    clear_obs();
    set_base(32'h100);
    put_desc(32'h100, 16'h8800, 16'd1, 32'h200);
    ctrl_en = 1'b0;
    do_kick();
    repeat (30) @(negedge clk);
    chk("R9", "no access while disabled", 32'(saw_req), 32'd0);
    chk("R9", "no events while disabled", 32'(n_txb), 32'd0);
    put_desc(32'h100, 16'h0000, 16'd0, 32'h0);
    ctrl_en = 1'b1;
  endtask

  task automatic t_single();
    clear_obs();
    bp = 1; mem_lat = 2;
    put_desc(32'h100, 16'h8805, 16'd6, 32'h201);
    put_desc(32'h108, 16'h0800, 16'd9, 32'h300);
    set_base(32'h103);
    do_kick();
    wait_idle();
    exp_bytes(32'h201, 6); exp_close();
    cmp_stream("R1 R5");
    chk("R4", "write-back header", bm[8'h40], 32'h0805_0006);
    chk("R4", "buffer word untouched", bm[8'h41], 32'h201);
    chk("R2", "unowned desc untouched", bm[8'h42], 32'h0800_0009);
    chk("R4", "txb count", 32'(n_txb), 32'd1);
    chk("R5", "txf count", 32'(n_txf), 32'd1);
    chk("R6", "no babt", 32'(n_babt), 32'd0);
  endtask

  task automatic t_chain();
    clear_obs();
    bp = 0; mem_lat = 0;
    put_desc(32'h108, 16'h8000, 16'd3, 32'h210);
    put_desc(32'h110, 16'h8800, 16'd0, 32'h0);
    put_desc(32'h118, 16'h8800, 16'd5, 32'h223);
    put_desc(32'h120, 16'h0000, 16'd0, 32'h0);
    do_kick();
    wait_idle();
    exp_bytes(32'h210, 3); exp_close();
    exp_bytes(32'h223, 5); exp_close();
    cmp_stream("R5 R2");
    chk("R5", "txf count", 32'(n_txf), 32'd2);
    chk("R4", "txb count", 32'(n_txb), 32'd3);
    chk("R4", "zero-length write-back", bm[8'h44], 32'h0800_0000);
  endtask

  task automatic t_trunc();
    clear_obs();
    bp = 1; mem_lat = 3;
    put_desc(32'h100, 16'h8000, 16'd12, 32'h240);
    put_desc(32'h108, 16'h8000, 16'd12, 32'h260);
    put_desc(32'h110, 16'h8800, 16'd4, 32'h280);
    put_desc(32'h118, 16'h8800, 16'd2, 32'h290);
    put_desc(32'h120, 16'h0000, 16'd0, 32'h0);
    set_base(32'h100);
    do_kick();
    wait_idle();
    exp_bytes(32'h240, 12); exp_bytes(32'h260, 8); exp_close();
    exp_bytes(32'h290, 2); exp_close();
    cmp_stream("R6");
    chk("R6", "babt count", 32'(n_babt), 32'd2);
    chk("R6", "txf count", 32'(n_txf), 32'd2);
    chk("R4", "truncated keeps length", bm[8'h42], 32'h0000_000C);
  endtask

  task automatic t_wrap();
    clear_obs();
    bp = 0; mem_lat = 1;
    put_desc(32'h130, 16'h8800, 16'd1, 32'h2A0);
    put_desc(32'h138, 16'hA800, 16'd2, 32'h2B0);
    put_desc(32'h140, 16'h8800, 16'd1, 32'h2C0);
    set_base(32'h130);
    do_kick();
    wait_idle();
    exp_bytes(32'h2A0, 1); exp_close();
    exp_bytes(32'h2B0, 2); exp_close();
    cmp_stream("R7");
    chk("R7", "slot after wrap-flag untouched", bm[8'h50], 32'h8800_0001);
    chk("R7", "txb count", 32'(n_txb), 32'd2);
    clear_obs();
    put_desc(32'h130, 16'h8800, 16'd1, 32'h2D0);
    do_kick();
    wait_idle();
    exp_bytes(32'h2D0, 1); exp_close();
    cmp_stream("R7 pointer at base");
  endtask

  task automatic t_limit();
    clear_obs();
    bp = 1; mem_lat = 0;
    for (int i = 0; i < 7; i++)
      put_desc(32'h100 + 32'(8*i), 16'h8800, 16'd1, 32'h300 + 32'(i));
    put_desc(32'h138, 16'h0000, 16'd0, 32'h0);
    set_base(32'h100);
    do_kick();
    wait_idle();
    chk("R3", "txb after first kick", 32'(n_txb), 32'(MD));
    chk("R3", "sixth slot still owned", bm[8'h4A], 32'h8800_0001);
    for (int i = 0; i < MD; i++) begin exp_bytes(32'h300 + 32'(i), 1); exp_close(); end
    cmp_stream("R3");
    clear_obs();
    do_kick();
    wait_idle();
    exp_bytes(32'h305, 1); exp_close();
    exp_bytes(32'h306, 1); exp_close();
    cmp_stream("R3 resume");
    chk("R3", "txb after second kick", 32'(n_txb), 32'd2);
  endtask

  initial begin
    for (int w = 0; w < 256; w++) begin
      logic [31:0] a;
      a = 32'(w) << 2;
      bm[w] = (w >= 128) ? {fb(a), fb(a + 1), fb(a + 2), fb(a + 3)} : 32'd0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_gate();
    t_single();
    t_chain();
    t_trunc();
    t_wrap();
    t_limit();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (done == 0) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule